// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Memory

This block stores the polyphase filter coefficients used by a video scaler. It holds six filter banks, one vertical and one horizontal bank for each of the luma, chroma and alpha planes. Only the first half of the phase circle, plus the centre phase, is stored for each bank. Reads of the other half are served by mirroring the phase and reversing the tap order.

Two complete copies of the memory exist. The datapath always reads the live copy. Software fills the other copy through a write port made of two parts. An address strobe loads the filter type, phase and tap pair. A data strobe then writes an even and an odd coefficient, each with its own enable, and the address steps on by itself. A swap request marks the loaded copy to become live. The change happens at the next frame-start pulse, so that no frame uses coefficients from both copies.

The block also decodes the fixed two-tap filter mode and its sharpening enable for each direction. A chroma-sharing input can make chroma reads fall back to the luma banks.

Top module: `scl_coef_mem`

## Requirements
- R1: After reset the live copy is copy 0, `rd_valid` is 0, `rd_coef` is 0, and the write address is type 0, phase 0, pair 0.
- R2: The filter type codes are 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical and 5 alpha horizontal. A data write always goes to the copy that is not live. Pair p holds tap 2p (even) and tap 2p+1 (odd). A write to type 6 or 7, to a phase above NPH/2, or to a pair above (`wr_taps_m1`>>1) changes no stored coefficient.
- R3: `dat_even_en` and `dat_odd_en` each gate only their own half of a data write.
- R4: Every coefficient is stored with its two least significant bits forced to 0.
- R5: When the tap count (`wr_taps_m1`+1) is odd, a write to the last pair, index `wr_taps_m1`>>1, stores the odd coefficient as 0.
- R6: Each data write advances the write address. The pair index steps first. After pair `wr_taps_m1`>>1 the pair returns to 0 and the phase steps, and after phase NPH/2 the phase returns to 0. An address strobe in the same cycle takes priority.
- R7: `swap_req` marks a pending swap. The live copy inverts at the next cycle with `frame_start` high if a swap is pending or `swap_req` is high in that same cycle, and at no other time. `active_bank` shows the live copy.
- R8: `rd_en` sampled at a clock edge gives `rd_valid`=1 and `rd_coef` from the live copy after that edge. A tap above `rd_taps_m1`, or a type of 6 or 7, reads as 0. While `rd_en` is low, `rd_valid` is 0 and `rd_coef` holds its value.
- R9: A read at phase p > NPH/2 returns the stored coefficient at phase NPH−p and tap `rd_taps_m1`−tap. Phase NPH/2 itself is read directly.
- R10: With `chroma_mode` low, reads of types 2 and 3 use types 0 and 1. With it high, they use their own banks. Alpha reads are never redirected.
- R11: `hard_h` (`hard_v`) is 1 exactly when both the luma and the chroma tap-count fields of that direction equal 1, that is two taps.
- R12: `sharp_h` (`sharp_v`) is 1 exactly when the matching hard flag is 1 and that direction's sharpness factor is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Load the write address |
| sel_type | input | 3 | Filter type for the write address |
| sel_phase | input | 6 | Phase for the write address |
| sel_pair | input | 2 | Tap pair for the write address |
| wr_taps_m1 | input | 3 | Tap count minus one of the filter being written |
| dat_we | input | 1 | Data write strobe |
| dat_even_en | input | 1 | Enable for the even coefficient |
| dat_odd_en | input | 1 | Enable for the odd coefficient |
| dat_even | input | 14 | Even-tap coefficient |
| dat_odd | input | 14 | Odd-tap coefficient |
| swap_req | input | 1 | Request to make the loaded copy live |
| frame_start | input | 1 | Frame-start pulse |
| active_bank | output | 1 | Currently live copy |
| chroma_mode | input | 1 | 1 = chroma uses its own banks |
| rd_en | input | 1 | Read strobe |
| rd_type | input | 3 | Read filter type |
| rd_phase | input | 6 | Read phase, 0 to 63 |
| rd_tap | input | 3 | Read tap index |
| rd_taps_m1 | input | 3 | Tap count minus one of the filter being read |
| rd_valid | output | 1 | Read data valid |
| rd_coef | output | 14 | Read coefficient |
| luma_h_taps_m1 | input | 3 | Horizontal luma tap count minus one |
| chroma_h_taps_m1 | input | 3 | Horizontal chroma tap count minus one |
| luma_v_taps_m1 | input | 3 | Vertical luma tap count minus one |
| chroma_v_taps_m1 | input | 3 | Vertical chroma tap count minus one |
| sharp_h_factor | input | 4 | Horizontal sharpness factor |
| sharp_v_factor | input | 4 | Vertical sharpness factor |
| hard_h | output | 1 | Horizontal fixed two-tap mode |
| hard_v | output | 1 | Vertical fixed two-tap mode |
| sharp_h | output | 1 | Horizontal sharpening enable |
| sharp_v | output | 1 | Vertical sharpening enable |

## Verification
A read returns `rd_coef` and `rd_valid` one edge after `rd_en` is sampled. `active_bank` inverts on the edge that samples `frame_start`. A written coefficient becomes readable only after the edge that performs the swap. The two-tap and sharpening flags follow their inputs within the same cycle. The bench drives inputs 2 ns after a rising edge. A behavioural model advances on each rising edge and is compared against every output at the falling edge. Directed checks sample 2 ns after the edge on which each result is due.

// File: rtl/scl_coef_pkg.sv
`timescale 1ns/1ps
package scl_coef_pkg;
    localparam int TYW   = 3;
    localparam int NTYPE = 6;

    typedef enum logic [TYW-1:0] {
        FT_LUMA_V   = 3'd0,
        FT_LUMA_H   = 3'd1,
        FT_CHROMA_V = 3'd2,
        FT_CHROMA_H = 3'd3,
        FT_ALPHA_V  = 3'd4,
        FT_ALPHA_H  = 3'd5
    } filt_type_e;
endpackage

// File: rtl/scl_coef_store.sv
`timescale 1ns/1ps
module scl_coef_store #(
    parameter int CW    = 14,
    parameter int DEPTH = 1584,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic [1:0]          we,
    input  logic [IW-1:0]       w_idx,
    input  logic [1:0][CW-1:0]  wdat,
    input  logic [IW-1:0]       r_idx,
    output logic [1:0][CW-1:0]  rdat
);
    // index 0 holds even taps, index 1 holds odd taps
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [CW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[h]) mem[w_idx] <= wdat[h];
        end
        assign rdat[h] = mem[r_idx];
    end
endmodule

// File: rtl/scl_rd_map.sv
`timescale 1ns/1ps
module scl_rd_map
    import scl_coef_pkg::*;
#(
    parameter int PW   = 6,
    parameter int TAPW = 3,
    parameter int NST  = 33
) (
    input  logic [TYW-1:0]  rd_type,
    input  logic [PW-1:0]   rd_phase,
    input  logic [TAPW-1:0] rd_tap,
    input  logic [TAPW-1:0] rd_taps_m1,
    input  logic            chroma_mode,
    output logic [TYW-1:0]  m_type,
    output logic [PW-1:0]   m_phase,
    output logic [TAPW-1:0] m_tap,
    output logic            m_blank
);
    localparam int NPH = 2 * (NST - 1);

    logic mirror;

    always_comb begin
        mirror  = rd_phase > PW'(NST - 1);
        m_phase = mirror ? PW'(NPH - int'(rd_phase)) : rd_phase;
        m_tap   = mirror ? (rd_taps_m1 - rd_tap) : rd_tap;
        m_blank = (rd_tap > rd_taps_m1) || (rd_type >= TYW'(NTYPE));
        if (!chroma_mode && (rd_type == FT_CHROMA_V || rd_type == FT_CHROMA_H))
            m_type = rd_type - TYW'(2);
        else
            m_type = rd_type;
    end
endmodule

// File: rtl/scl_twotap_dir.sv
`timescale 1ns/1ps
module scl_twotap_dir #(
    parameter int TAPW = 3,
    parameter int SFW  = 4
) (
    input  logic [TAPW-1:0] luma_m1,
    input  logic [TAPW-1:0] chroma_m1,
    input  logic [SFW-1:0]  factor,
    output logic            hard,
    output logic            sharp
);
    always_comb begin
        hard  = (luma_m1 == TAPW'(1)) && (chroma_m1 == TAPW'(1));
        sharp = hard && (factor != '0);
    end
endmodule

// File: rtl/scl_coef_mem.sv
`timescale 1ns/1ps
module scl_coef_mem
    import scl_coef_pkg::*;
#(
    parameter int CW       = 14,
    parameter int NPH      = 64,
    parameter int MAX_TAPS = 8,
    parameter int SFW      = 4,
    localparam int PW      = $clog2(NPH),
    localparam int TAPW    = $clog2(MAX_TAPS),
    localparam int PAIRS   = MAX_TAPS / 2,
    localparam int PRW     = $clog2(PAIRS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_we,
    input  logic [TYW-1:0]  sel_type,
    input  logic [PW-1:0]   sel_phase,
    input  logic [PRW-1:0]  sel_pair,
    input  logic [TAPW-1:0] wr_taps_m1,
    input  logic            dat_we,
    input  logic            dat_even_en,
    input  logic            dat_odd_en,
    input  logic [CW-1:0]   dat_even,
    input  logic [CW-1:0]   dat_odd,
    input  logic            swap_req,
    input  logic            frame_start,
    output logic            active_bank,
    input  logic            chroma_mode,
    input  logic            rd_en,
    input  logic [TYW-1:0]  rd_type,
    input  logic [PW-1:0]   rd_phase,
    input  logic [TAPW-1:0] rd_tap,
    input  logic [TAPW-1:0] rd_taps_m1,
    output logic            rd_valid,
    output logic [CW-1:0]   rd_coef,
    input  logic [TAPW-1:0] luma_h_taps_m1,
    input  logic [TAPW-1:0] chroma_h_taps_m1,
    input  logic [TAPW-1:0] luma_v_taps_m1,
    input  logic [TAPW-1:0] chroma_v_taps_m1,
    input  logic [SFW-1:0]  sharp_h_factor,
    input  logic [SFW-1:0]  sharp_v_factor,
    output logic            hard_h,
    output logic            hard_v,
    output logic            sharp_h,
    output logic            sharp_v
);
    localparam int NST   = NPH / 2 + 1;
    localparam int DEPTH = 2 * NTYPE * NST * PAIRS;
    localparam int IW    = $clog2(DEPTH);
    localparam logic [CW-1:0] LOW_MASK = ~CW'(3);

    typedef struct packed {
        logic           bank;
        logic           pend;
        logic [TYW-1:0] wtype;
        logic [PW-1:0]  wphase;
        logic [PRW-1:0] wpair;
        logic           rvalid;
        logic [CW-1:0]  rcoef;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [IW-1:0] flat_idx(input logic b, input logic [TYW-1:0] t,
                                               input logic [PW-1:0] ph, input logic [PRW-1:0] pr);
        return IW'(((int'(b) * NTYPE + int'(t)) * NST + int'(ph)) * PAIRS + int'(pr));
    endfunction

    logic [1:0]          we_v;
    logic [IW-1:0]       w_idx, r_idx;
    logic [1:0][CW-1:0]  wdat, rdat;
    logic [PRW-1:0]      wlast;
    logic                w_ok, odd_blank;
    logic [TYW-1:0]      m_type;
    logic [PW-1:0]       m_phase;
    logic [TAPW-1:0]     m_tap;
    logic                m_blank;

    scl_coef_store #(.CW(CW), .DEPTH(DEPTH)) i_store (
        .clk(clk), .we(we_v), .w_idx(w_idx), .wdat(wdat), .r_idx(r_idx), .rdat(rdat)
    );

    scl_rd_map #(.PW(PW), .TAPW(TAPW), .NST(NST)) i_map (
        .rd_type(rd_type), .rd_phase(rd_phase), .rd_tap(rd_tap), .rd_taps_m1(rd_taps_m1),
        .chroma_mode(chroma_mode), .m_type(m_type), .m_phase(m_phase), .m_tap(m_tap),
        .m_blank(m_blank)
    );

    logic [1:0][TAPW-1:0] tt_luma, tt_chroma;
    logic [1:0][SFW-1:0]  tt_fac;
    logic [1:0]           tt_hard, tt_sharp;

    assign tt_luma   = {luma_v_taps_m1, luma_h_taps_m1};
    assign tt_chroma = {chroma_v_taps_m1, chroma_h_taps_m1};
    assign tt_fac    = {sharp_v_factor, sharp_h_factor};

    for (genvar d = 0; d < 2; d++) begin : g_dir
        scl_twotap_dir #(.TAPW(TAPW), .SFW(SFW)) i_dir (
            .luma_m1(tt_luma[d]), .chroma_m1(tt_chroma[d]), .factor(tt_fac[d]),
            .hard(tt_hard[d]), .sharp(tt_sharp[d])
        );
    end

    assign hard_h  = tt_hard[0];
    assign hard_v  = tt_hard[1];
    assign sharp_h = tt_sharp[0];
    assign sharp_v = tt_sharp[1];

    always_comb begin
        st_d = st_q;

        // write side: always targets the copy that is not live
        wlast     = PRW'(wr_taps_m1 >> 1);
        w_ok      = dat_we && (st_q.wtype < TYW'(NTYPE)) &&
                    (st_q.wphase <= PW'(NST - 1)) && (st_q.wpair <= wlast);
        odd_blank = (st_q.wpair == wlast) && !wr_taps_m1[0];
        we_v      = {w_ok & dat_odd_en, w_ok & dat_even_en};
        wdat[0]   = dat_even & LOW_MASK;
        wdat[1]   = odd_blank ? '0 : (dat_odd & LOW_MASK);
        w_idx     = flat_idx(~st_q.bank, st_q.wtype, st_q.wphase, st_q.wpair);

        if (dat_we) begin
            if (st_q.wpair >= wlast) begin
                st_d.wpair  = '0;
                st_d.wphase = (st_q.wphase >= PW'(NST - 1)) ? '0 : st_q.wphase + 1'b1;
            end else begin
                st_d.wpair = st_q.wpair + 1'b1;
            end
        end
        if (sel_we) begin
            st_d.wtype  = sel_type;
            st_d.wphase = sel_phase;
            st_d.wpair  = sel_pair;
        end

        // copy swap at frame boundary only
        if (frame_start) begin
            st_d.bank = st_q.bank ^ (st_q.pend | swap_req);
            st_d.pend = 1'b0;
        end else if (swap_req) begin
            st_d.pend = 1'b1;
        end

        // read side from the live copy
        r_idx       = flat_idx(st_q.bank, m_type, m_phase, PRW'(m_tap >> 1));
        st_d.rvalid = rd_en;
        if (rd_en)
            st_d.rcoef = m_blank ? '0 : (m_tap[0] ? rdat[1] : rdat[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_bank = st_q.bank;
    assign rd_valid    = st_q.rvalid;
    assign rd_coef     = st_q.rcoef;

    a_r7_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> active_bank == $past(active_bank));

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_coef)));

    a_r8_blank_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_tap > rd_taps_m1)) |=> rd_coef == '0);

    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_coef[1:0] == 2'b00);

    a_r6_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !sel_we && (st_q.wpair < PRW'(wr_taps_m1 >> 1)))
        |=> st_q.wpair == $past(st_q.wpair) + 1'b1);
endmodule

// File: tb/test_scl_coef_mem.sv
`timescale 1ns/1ps
module test_scl_coef_mem;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_we = 0, dat_we = 0, dat_even_en = 0, dat_odd_en = 0;
    logic [2:0] sel_type = 0, wr_taps_m1 = 0, rd_type = 0, rd_tap = 0, rd_taps_m1 = 0;
    logic [5:0] sel_phase = 0, rd_phase = 0;
    logic [1:0] sel_pair = 0;
    logic [13:0] dat_even = 0, dat_odd = 0;
    logic swap_req = 0, frame_start = 0, chroma_mode = 0, rd_en = 0;
    logic [2:0] luma_h_taps_m1 = 0, chroma_h_taps_m1 = 0, luma_v_taps_m1 = 0, chroma_v_taps_m1 = 0;
    logic [3:0] sharp_h_factor = 0, sharp_v_factor = 0;
    logic active_bank, rd_valid, hard_h, hard_v, sharp_h, sharp_v;
    logic [13:0] rd_coef;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scl_coef_mem i_scl_coef_mem (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_type(sel_type), .sel_phase(sel_phase),
        .sel_pair(sel_pair), .wr_taps_m1(wr_taps_m1), .dat_we(dat_we), .dat_even_en(dat_even_en),
        .dat_odd_en(dat_odd_en), .dat_even(dat_even), .dat_odd(dat_odd), .swap_req(swap_req),
        .frame_start(frame_start), .active_bank(active_bank), .chroma_mode(chroma_mode),
        .rd_en(rd_en), .rd_type(rd_type), .rd_phase(rd_phase), .rd_tap(rd_tap),
        .rd_taps_m1(rd_taps_m1), .rd_valid(rd_valid), .rd_coef(rd_coef),
        .luma_h_taps_m1(luma_h_taps_m1), .chroma_h_taps_m1(chroma_h_taps_m1),
        .luma_v_taps_m1(luma_v_taps_m1), .chroma_v_taps_m1(chroma_v_taps_m1),
        .sharp_h_factor(sharp_h_factor), .sharp_v_factor(sharp_v_factor),
        .hard_h(hard_h), .hard_v(hard_v), .sharp_h(sharp_h), .sharp_v(sharp_v)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pat(input int b, input int t, input int ph, input int pr, input int o);
        return (b * 4099 + t * 577 + ph * 37 + pr * 11 + o * 5 + 3) & 'h3fff;
    endfunction

    function automatic int st(input int v);
        return v & 'h3ffc;
    endfunction

    // behavioural reference model
    int mem [2][6][33][8];
    int m_bank, m_pend, m_wt, m_wph, m_wpr, e_rv, e_rc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank = 0; m_pend = 0; m_wt = 0; m_wph = 0; m_wpr = 0; e_rv = 0; e_rc = 0;
        end else begin
            if (rd_en) begin
                int t, ph, tp, tm;
                t = rd_type; ph = rd_phase; tp = rd_tap; tm = rd_taps_m1;
                e_rv = 1;
                if (tp > tm || t > 5) e_rc = 0;
                else begin
                    if (!chroma_mode && (t == 2 || t == 3)) t = t - 2;
                    if (ph > 32) begin ph = 64 - ph; tp = tm - tp; end
                    e_rc = mem[m_bank][t][ph][tp];
                end
            end else e_rv = 0;
            if (dat_we) begin
                int last, wb;
                last = wr_taps_m1 / 2; wb = 1 - m_bank;
                if (m_wt < 6 && m_wph < 33 && m_wpr <= last) begin
                    if (dat_even_en) mem[wb][m_wt][m_wph][2*m_wpr] = st(int'(dat_even));
                    if (dat_odd_en)
                        mem[wb][m_wt][m_wph][2*m_wpr+1] =
                            (m_wpr == last && wr_taps_m1 % 2 == 0) ? 0 : st(int'(dat_odd));
                end
                if (m_wpr >= last) begin m_wpr = 0; m_wph = (m_wph >= 32) ? 0 : m_wph + 1; end
                else m_wpr = m_wpr + 1;
            end
            if (sel_we) begin m_wt = sel_type; m_wph = sel_phase; m_wpr = sel_pair; end
            if (frame_start) begin
                if (m_pend != 0 || swap_req) m_bank = 1 - m_bank;
                m_pend = 0;
            end else if (swap_req) m_pend = 1;
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int hh, hv;
            hh = (luma_h_taps_m1 == 1 && chroma_h_taps_m1 == 1) ? 1 : 0;
            hv = (luma_v_taps_m1 == 1 && chroma_v_taps_m1 == 1) ? 1 : 0;
            cmp("R8 rd_valid", 32'(rd_valid), e_rv);
            cmp("R8 rd_coef", 32'(rd_coef), e_rc);
            cmp("R7 active_bank", 32'(active_bank), m_bank);
            cmp("R11 hard_h", 32'(hard_h), hh);
            cmp("R11 hard_v", 32'(hard_v), hv);
            cmp("R12 sharp_h", 32'(sharp_h), (hh != 0 && sharp_h_factor != 0) ? 1 : 0);
            cmp("R12 sharp_v", 32'(sharp_v), (hv != 0 && sharp_v_factor != 0) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic set_addr(input int t, input int ph, input int pr);
        sel_we = 1; sel_type = 3'(t); sel_phase = 6'(ph); sel_pair = 2'(pr);
        tick(); sel_we = 0;
    endtask

    task automatic wr(input int ev, input int od, input bit een, input bit oen, input int tm);
        dat_we = 1; dat_even = 14'(ev); dat_odd = 14'(od);
        dat_even_en = een; dat_odd_en = oen; wr_taps_m1 = 3'(tm);
        tick(); dat_we = 0;
    endtask

    task automatic swap_now();
        swap_req = 1; frame_start = 1; tick(); swap_req = 0; frame_start = 0;
    endtask

    task automatic rd(input int t, input int ph, input int tp, input int tm);
        rd_en = 1; rd_type = 3'(t); rd_phase = 6'(ph); rd_tap = 3'(tp); rd_taps_m1 = 3'(tm);
        tick(); rd_en = 0;
    endtask

    task automatic fill(input int b);
        for (int t = 0; t < 6; t++) begin
            set_addr(t, 0, 0);
            for (int ph = 0; ph < 33; ph++)
                for (int pr = 0; pr < 4; pr++)
                    wr(pat(b, t, ph, pr, 0), pat(b, t, ph, pr, 1), 1, 1, 7);
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        cmp("R1 active_bank after reset", 32'(active_bank), 0);
        cmp("R1 rd_valid after reset", 32'(rd_valid), 0);
        cmp("R1 rd_coef after reset", 32'(rd_coef), 0);

        fill(1);
        cmp("R2 writes leave live copy", 32'(active_bank), 0);
        swap_req = 1; tick(); swap_req = 0;
        repeat (3) tick();
        cmp("R7 pending swap waits", 32'(active_bank), 0);
        frame_start = 1; tick(); frame_start = 0;
        cmp("R7 swap at frame start", 32'(active_bank), 1);
        frame_start = 1; tick(); frame_start = 0;
        cmp("R7 frame start without request", 32'(active_bank), 1);
        fill(0);

        // R6: pointer walked all pairs/phases during fill
        rd(1, 5, 3, 7);
        cmp("R8 read latency valid", 32'(rd_valid), 1);
        cmp("R6 R8 read luma horz", 32'(rd_coef), st(pat(1, 1, 5, 1, 1)));
        cmp("R4 low bits zero", 32'(rd_coef[1:0]), 0);
        repeat (2) tick();
        cmp("R8 hold when idle", 32'(rd_coef), st(pat(1, 1, 5, 1, 1)));
        cmp("R8 valid low when idle", 32'(rd_valid), 0);
        rd(0, 40, 2, 7);
        cmp("R9 mirror phase 40", 32'(rd_coef), st(pat(1, 0, 24, 2, 1)));
        rd(0, 32, 1, 7);
        cmp("R9 centre phase direct", 32'(rd_coef), st(pat(1, 0, 32, 0, 1)));
        rd(0, 63, 0, 3);
        cmp("R9 mirror phase 63 four taps", 32'(rd_coef), st(pat(1, 0, 1, 1, 1)));
        rd(1, 7, 6, 3);
        cmp("R8 tap beyond count", 32'(rd_coef), 0);
        rd(2, 2, 2, 7);
        rd(6, 2, 2, 7);
        cmp("R8 invalid type reads zero", 32'(rd_coef), 0);

        chroma_mode = 0;
        rd(3, 7, 0, 7);
        cmp("R10 chroma shares luma", 32'(rd_coef), st(pat(1, 1, 7, 0, 0)));
        rd(5, 7, 0, 7);
        cmp("R10 alpha not redirected", 32'(rd_coef), st(pat(1, 5, 7, 0, 0)));
        chroma_mode = 1;
        rd(3, 7, 0, 7);
        cmp("R10 chroma own bank", 32'(rd_coef), st(pat(1, 3, 7, 0, 0)));

        // R3 separate enables, into copy 0
        set_addr(4, 10, 1);
        wr('h1235, 'h0aaa, 1, 0, 7);
        swap_now();
        cmp("R7 same-cycle request swaps", 32'(active_bank), 0);
        rd(4, 10, 2, 7);
        cmp("R3 even written R4 masked", 32'(rd_coef), 'h1234);
        rd(4, 10, 3, 7);
        cmp("R3 odd untouched", 32'(rd_coef), st(pat(0, 4, 10, 1, 1)));

        // R5 odd tap count, into copy 1
        set_addr(2, 3, 2);
        wr('h2001, 'h1ff0, 1, 1, 4);
        set_addr(2, 3, 1);
        wr('h0444, 'h0888, 1, 1, 4);
        swap_now();
        rd(2, 3, 4, 7);
        cmp("R5 last pair even kept", 32'(rd_coef), 'h2000);
        rd(2, 3, 5, 7);
        cmp("R5 last pair odd zeroed", 32'(rd_coef), 0);
        rd(2, 3, 3, 7);
        cmp("R5 earlier pair odd kept", 32'(rd_coef), 'h0888);

        // R6 phase wrap after NPH/2, into copy 0
        set_addr(0, 32, 1);
        wr('h0100, 'h0200, 1, 1, 3);
        wr('h0300, 'h0400, 1, 1, 3);
        swap_now();
        rd(0, 32, 2, 3);
        cmp("R6 write at phase 32", 32'(rd_coef), 'h0100);
        rd(0, 0, 0, 3);
        cmp("R6 wrapped to phase 0 pair 0", 32'(rd_coef), 'h0300);
        rd(0, 0, 1, 3);
        cmp("R6 wrapped odd", 32'(rd_coef), 'h0400);

        // R2 out-of-range writes, into copy 1 (phase 40) then copy 0 (type 6)
        set_addr(0, 40, 0);
        wr('h3ff0, 'h3ff0, 1, 1, 7);
        swap_now();
        rd(1, 7, 0, 7);
        cmp("R2 bad phase ignored", 32'(rd_coef), st(pat(1, 1, 7, 0, 0)));
        set_addr(6, 0, 0);
        wr('h3ff0, 'h3ff0, 1, 1, 7);
        rd(0, 0, 0, 7);
        cmp("R2 bad type ignored", 32'(rd_coef), st(pat(1, 0, 0, 0, 0)));

        // R11 R12
        luma_h_taps_m1 = 1; chroma_h_taps_m1 = 1; sharp_h_factor = 0; tick();
        cmp("R11 hard_h both two taps", 32'(hard_h), 1);
        cmp("R12 sharp_h zero factor", 32'(sharp_h), 0);
        sharp_h_factor = 3; tick();
        cmp("R12 sharp_h nonzero factor", 32'(sharp_h), 1);
        chroma_h_taps_m1 = 2; tick();
        cmp("R11 hard_h chroma three taps", 32'(hard_h), 0);
        cmp("R12 sharp_h needs hard", 32'(sharp_h), 0);
        luma_v_taps_m1 = 1; chroma_v_taps_m1 = 1; sharp_v_factor = 5; tick();
        cmp("R11 hard_v", 32'(hard_v), 1);
        cmp("R12 sharp_v", 32'(sharp_v), 1);
        luma_v_taps_m1 = 0; tick();
        cmp("R11 hard_v one tap", 32'(hard_v), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule